// File: doc/BRIEF.md
# Half-Bridge Output Controller with Supply Fault Lockout

This block is the digital control core for a pair of half-bridge power outputs. Each output has a high-side and a low-side switch. The block combines the register settings with two external PWM pins and with the fault comparator flags. From these it produces, for each output, a high-side enable, a low-side enable and a high-impedance indication. It also keeps a set of sticky status bits.

A mode bit moves the block between standby and active. In standby both outputs are off. After the block becomes active, the outputs wait for a parameterised activation delay. During PWM operation the output alternates between its high side and active freewheeling on its low side. The PWM pin for each output is picked through a swap map.

A supply under- or overvoltage forces both outputs to high impedance. An overcurrent turns off only the output it was flagged for. A recovery-mode bit selects what happens when the supply returns. With the bit clear, the outputs come back on their own. With the bit set, they stay off until software clears the status bits.

Top module: `hbridge_ctrl`

## Requirements
- R1: After reset, and on the clock edge after `mode_active` is sampled low, both outputs are high impedance: `hiz`=2'b11, `hs_en`=`ls_en`=2'b00. After reset, `glob_fault` is 0.
- R2: After `mode_active` rises, the outputs stay high impedance for ACT_DLY edges and take their programmed state on edge ACT_DLY+1. A return to standby cancels the count, and the next rise starts it again from zero.
- R3: `cfg_state[2i+1:2i]` programs output i+1 as follows: 2'b10 turns the high side on, 2'b01 turns the low side on, and 2'b00 or 2'b11 leaves the output high impedance.
- R4: When `pwm_en[i]` is 1 and the output is programmed high side, a high PWM level turns the high side on. A low PWM level turns the low side on (freewheeling). The PWM pins pass through two synchronizer flops. When `pwm_en[i]` is 0, the PWM pin has no effect.
- R5: With `pwm_swap`=0, output 1 uses `pwm_in[0]` and output 2 uses `pwm_in[1]`. With `pwm_swap`=1, both outputs use `pwm_in[0]`.
- R6: `hs_en[i]` and `ls_en[i]` are never 1 together. A change between high side and low side passes through one cycle with both switches off.
- R7: With `uv_flag` high at an edge, both outputs are high impedance after that edge, and `stat_uv` and `glob_fault` are 1.
- R8: With `ov_flag` high at an edge, both outputs are high impedance after that edge, and `stat_ov` and `glob_fault` are 1.
- R9: With `oc_flag[i]` high at an edge, output i+1 is high impedance after that edge and `stat_oc[i]` is 1. The other output is unaffected. Output i+1 stays off until `stat_oc[i]` has been cleared.
- R10: With `recov_hold`=0, the outputs return to their programmed state on the first edge at which neither supply flag is high.
- R11: With `recov_hold`=1, the outputs stay high impedance after the supply returns. They come back on the edge after the one at which the clear takes effect.
- R12: Status bits are sticky and clear only at an edge with `stat_clr` high. A clear has no effect on a bit whose flag is still high. `glob_fault` is the OR of all status bits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| mode_active | input | 1 | 1 = active, 0 = standby |
| cfg_state | input | 4 | Programmed state, two bits per output |
| pwm_en | input | 2 | PWM modulation enable, one bit per output |
| pwm_swap | input | 1 | 1 = both outputs use PWM pin 1 |
| recov_hold | input | 1 | 1 = hold outputs off after a supply fault until status is cleared |
| pwm_in | input | 2 | Asynchronous PWM pins |
| uv_flag | input | 1 | Supply undervoltage comparator |
| ov_flag | input | 1 | Supply overvoltage comparator |
| oc_flag | input | 2 | Per-output overcurrent comparator |
| stat_clr | input | 1 | Status clear strobe |
| hs_en | output | 2 | High-side switch enable per output |
| ls_en | output | 2 | Low-side switch enable per output |
| hiz | output | 2 | Output high impedance per output |
| glob_fault | output | 1 | Multi-cause global fault bit |
| stat_uv | output | 1 | Sticky undervoltage status |
| stat_ov | output | 1 | Sticky overvoltage status |
| stat_oc | output | 2 | Sticky per-output overcurrent status |

## Verification
The PWM path is tested in three ways:
- With the swap bit clear, the two pins are driven to opposite levels, which shows that each output follows its own pin.
- With the swap bit set, the same input pattern shows that output 2 now tracks pin 1.
- With the enable bit clear, the pin is toggled, which shows that it is ignored.

A high-to-low PWM step is sampled cycle by cycle. This separates the synchronizer latency from the dead cycle. The supply fault sequences run once with each recovery setting, and a clear is attempted while the flag is still high. This distinguishes automatic restore, held lockout and a premature clear. An overcurrent on one output shows that the lockout stays local to that output.

// File: rtl/hbridge_ctrl.sv
module hbridge_ctrl #(
  parameter int ACT_DLY = 8
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       mode_active,
  input  logic [3:0] cfg_state,
  input  logic [1:0] pwm_en,
  input  logic       pwm_swap,
  input  logic       recov_hold,
  input  logic [1:0] pwm_in,
  input  logic       uv_flag,
  input  logic       ov_flag,
  input  logic [1:0] oc_flag,
  input  logic       stat_clr,
  output logic [1:0] hs_en,
  output logic [1:0] ls_en,
  output logic [1:0] hiz,
  output logic       glob_fault,
  output logic       stat_uv,
  output logic       stat_ov,
  output logic [1:0] stat_oc
);
  localparam int CW = $clog2(ACT_DLY + 1);
  localparam logic [1:0] ST_OFF = 2'b00;
  localparam logic [1:0] ST_LS  = 2'b01;
  localparam logic [1:0] ST_HS  = 2'b10;

  logic [1:0] pwm_m, pwm_s;
  logic [CW-1:0] cnt;
  logic ready, supply_lock;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      pwm_m <= '0;
      pwm_s <= '0;
    end else begin
      pwm_m <= pwm_in;
      pwm_s <= pwm_m;
    end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) cnt <= '0;
    else if (!mode_active) cnt <= '0;
    else if (cnt != CW'(ACT_DLY)) cnt <= cnt + 1'b1;

  assign ready = mode_active && (cnt == CW'(ACT_DLY));
  assign supply_lock = uv_flag || ov_flag || (recov_hold && (stat_uv || stat_ov));

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      stat_uv <= 1'b0;
      stat_ov <= 1'b0;
      stat_oc <= '0;
    end else begin
      stat_uv <= uv_flag || (stat_uv && !stat_clr);
      stat_ov <= ov_flag || (stat_ov && !stat_clr);
      stat_oc <= oc_flag | (stat_oc & {2{!stat_clr}});
    end

  assign glob_fault = stat_uv || stat_ov || (|stat_oc);

  for (genvar i = 0; i < 2; i++) begin : g_out
    logic [1:0] prog, req, tgt, cur;
    logic psel;
    assign psel = (i == 1 && !pwm_swap) ? pwm_s[1] : pwm_s[0];
    assign prog = cfg_state[2*i +: 2];
    always_comb begin
      req = (prog == 2'b11) ? ST_OFF : prog;
      if (pwm_en[i] && req == ST_HS && !psel) req = ST_LS;
      tgt = (ready && !supply_lock && !stat_oc[i] && !oc_flag[i]) ? req : ST_OFF;
    end
    always_ff @(posedge clk or negedge rst_n)
      if (!rst_n) cur <= ST_OFF;
      else if (tgt != cur) cur <= (cur != ST_OFF) ? ST_OFF : tgt;
    assign hs_en[i] = (cur == ST_HS);
    assign ls_en[i] = (cur == ST_LS);
    assign hiz[i]   = (cur == ST_OFF);
  end
endmodule

// File: rtl/hbridge_ctrl_chk.sv
module hbridge_ctrl_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       mode_active,
  input logic       uv_flag,
  input logic       ov_flag,
  input logic [1:0] oc_flag,
  input logic       stat_clr,
  input logic [1:0] hs_en,
  input logic [1:0] ls_en,
  input logic [1:0] hiz,
  input logic       glob_fault,
  input logic       stat_uv,
  input logic       stat_ov,
  input logic [1:0] stat_oc
);
  assert_standby_off_R1: assert property (@(posedge clk) disable iff (!rst_n)
    !mode_active |=> hiz == 2'b11);
  assert_no_overlap_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (hs_en & ls_en) == 2'b00);
  assert_dead_hs0_R6: assert property (@(posedge clk) disable iff (!rst_n)
    hs_en[0] |=> !ls_en[0]);
  assert_dead_hs1_R6: assert property (@(posedge clk) disable iff (!rst_n)
    hs_en[1] |=> !ls_en[1]);
  assert_uv_off_R7: assert property (@(posedge clk) disable iff (!rst_n)
    uv_flag |=> (hiz == 2'b11) && stat_uv && glob_fault);
  assert_ov_off_R8: assert property (@(posedge clk) disable iff (!rst_n)
    ov_flag |=> (hiz == 2'b11) && stat_ov && glob_fault);
  assert_oc_off_R9: assert property (@(posedge clk) disable iff (!rst_n)
    oc_flag[1] |=> hiz[1] && stat_oc[1]);
  assert_uv_sticky_R12: assert property (@(posedge clk) disable iff (!rst_n)
    stat_uv && !stat_clr |=> stat_uv);
  assert_clr_blocked_R12: assert property (@(posedge clk) disable iff (!rst_n)
    stat_clr && ov_flag |=> stat_ov);
endmodule

bind hbridge_ctrl hbridge_ctrl_chk chk_i (
  .clk(clk), .rst_n(rst_n), .mode_active(mode_active), .uv_flag(uv_flag),
  .ov_flag(ov_flag), .oc_flag(oc_flag), .stat_clr(stat_clr), .hs_en(hs_en),
  .ls_en(ls_en), .hiz(hiz), .glob_fault(glob_fault), .stat_uv(stat_uv),
  .stat_ov(stat_ov), .stat_oc(stat_oc)
);

// File: tb/hbridge_ctrl_tb_top.sv
module hbridge_ctrl_tb_top;
  localparam int DLY = 8;
  logic clk = 1'b0, rst_n = 1'b0;
  logic mode_active = 0, pwm_swap = 0, recov_hold = 0, uv_flag = 0, ov_flag = 0, stat_clr = 0;
  logic [3:0] cfg_state = '0;
  logic [1:0] pwm_en = '0, pwm_in = '0, oc_flag = '0;
  logic [1:0] hs_en, ls_en, hiz, stat_oc;
  logic glob_fault, stat_uv, stat_ov;
  int checks = 0, errors = 0;

  always #2 clk = ~clk;

  hbridge_ctrl #(.ACT_DLY(DLY)) dut_i (.*);

  function automatic logic [5:0] ex(int c1, int c0);
    return {c1 == 2, c0 == 2, c1 == 1, c0 == 1, c1 == 0, c0 == 0};
  endfunction

  task automatic chk(string req, logic [7:0] act, logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic outs(string req, logic [5:0] exp);
    chk(req, {2'b0, hs_en, ls_en, hiz}, {2'b0, exp});
  endtask

  task automatic step(int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic clear_status();
    stat_clr = 1; step(1); stat_clr = 0;
  endtask

  task automatic t_reset();
    outs("R1 reset", ex(0, 0));
    chk("R1 reset glob", {7'b0, glob_fault}, 8'h00);
  endtask

  task automatic t_activate();
    cfg_state = 4'b0110; mode_active = 1;
    step(3); mode_active = 0; step(1);
    outs("R1 standby", ex(0, 0));
    mode_active = 1; step(DLY);
    outs("R2 delay restarted", ex(0, 0));
    step(1);
    outs("R2 R3 active states", ex(1, 2));
    cfg_state = 4'b1100; step(1);
    outs("R3 off codes", ex(0, 0));
    cfg_state = 4'b1001; step(1);
    outs("R3 swapped states", ex(2, 1));
  endtask

  task automatic t_pwm();
    cfg_state = 4'b1010; pwm_en = 2'b11; pwm_swap = 0; pwm_in = 2'b01;
    step(4);
    outs("R5 own pins", ex(1, 2));
    pwm_in = 2'b00; step(2);
    outs("R4 sync latency", ex(1, 2));
    step(1);
    outs("R6 dead cycle", ex(1, 0));
    step(1);
    outs("R4 freewheel", ex(1, 1));
    pwm_in = 2'b01; step(4);
    pwm_swap = 1; step(1);
    outs("R6 dead on swap", ex(0, 2));
    step(1);
    outs("R5 swap map", ex(2, 2));
    pwm_swap = 0; pwm_en = 2'b00; pwm_in = 2'b00; step(6);
    outs("R4 pwm ignored", ex(2, 2));
  endtask

  task automatic t_uv();
    cfg_state = 4'b0110; recov_hold = 0; step(3);
    uv_flag = 1; step(1);
    outs("R7 uv off", ex(0, 0));
    chk("R7 uv status", {6'b0, stat_uv, glob_fault}, 8'h03);
    uv_flag = 0; step(1);
    outs("R10 auto restore", ex(1, 2));
    chk("R12 uv sticky", {7'b0, stat_uv}, 8'h01);
    clear_status();
    chk("R12 uv cleared", {7'b0, stat_uv}, 8'h00);
    recov_hold = 1; uv_flag = 1; step(1);
    stat_clr = 1; step(1); stat_clr = 0;
    chk("R12 clear ignored", {7'b0, stat_uv}, 8'h01);
    uv_flag = 0; step(3);
    outs("R11 held off", ex(0, 0));
    clear_status();
    outs("R11 still off at clear", ex(0, 0));
    step(1);
    outs("R11 restored", ex(1, 2));
    recov_hold = 0;
  endtask

  task automatic t_ov();
    ov_flag = 1; step(1);
    outs("R8 ov off", ex(0, 0));
    chk("R8 ov status", {6'b0, stat_ov, glob_fault}, 8'h03);
    ov_flag = 0; step(1);
    outs("R10 ov restore", ex(1, 2));
    clear_status();
    chk("R12 glob cleared", {7'b0, glob_fault}, 8'h00);
  endtask

  task automatic t_oc();
    oc_flag = 2'b10; step(1);
    outs("R9 oc local", ex(0, 2));
    chk("R9 oc status", {5'b0, stat_oc, glob_fault}, 8'h05);
    oc_flag = 2'b00; step(3);
    outs("R9 oc held", ex(0, 2));
    clear_status();
    chk("R9 oc cleared", {6'b0, stat_oc}, 8'h00);
    step(1);
    outs("R9 oc restored", ex(1, 2));
  endtask

  initial begin
    fork
      begin
        step(2); rst_n = 1; step(1);
        t_reset();
        t_activate();
        t_pwm();
        t_uv();
        t_ov();
        t_oc();
      end
      begin
        repeat (20000) @(posedge clk);
        errors++; checks++;
        $display("FAIL watchdog actual=running expected=done");
      end
    join_any
    disable fork;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule